// File: doc/BRIEF.md
# Opcode Decoder with Cycle Budget

This block accepts an 8-bit opcode for an 8-bit accumulator processor, splits it into an operation group, an operation field and an addressing-mode field, and flags opcodes that have no implementation. For each legal opcode it loads a base cycle count, which it computes from the opcode, and counts the instruction's cycles down to a single-cycle done pulse.

For conditional branches the budget is not fixed. If the branch is taken, it grows by one cycle. If the taken branch also moves the program counter to a new 256-byte page, it grows by one more. The sequencer drives the opcode with a valid strobe and receives `done_o` in the last cycle of the instruction. That same cycle is the one in which the next opcode may already be strobed.

Top module: `op_cycle_ctl`

## Requirements
- R1: After an accepted strobe, `group_o` holds opcode bits [1:0], `mode_o` holds bits [4:2] and `op_o` holds bits [7:5]. These outputs do not change without a further accepted strobe. After reset all outputs are 0.
- R2: Every opcode whose bits [1:0] are 2'b11 raises `illegal_o`.
- R3: An opcode with no implementation raises `illegal_o` and starts no countdown, so no `done_o` follows. Examples are 0x02, 0x04, 0x89, 0x9E and 0xDA.
- R4: For a legal opcode with base count N, `done_o` is high in the Nth cycle after the strobe cycle. Sample base counts:
  - 0x00 takes 7 cycles.
  - 0x20 takes 6 cycles.
  - 0xA9 takes 2 cycles.
  - 0x1E takes 7 cycles.
  - 0x9D takes 5 cycles.
  - 0xAD takes 4 cycles.
  - A conditional branch takes 2 cycles.
- R5: The conditional branches are the opcodes with bits [1:0]=00 and bits [4:2]=100. When `taken_i` is high for such an opcode, the count grows by 1.
- R6: If a branch is taken and `page_cross_i` is high as well, the count grows by 1 more. A `page_cross_i` without `taken_i` has no effect.
- R7: `done_o` is high for exactly one clock per instruction.
- R8: A strobe in the cycle where `done_o` is high is accepted and reloads the count for the new opcode.
- R9: A strobe while a countdown is running and `done_o` is low is ignored. It changes neither the outputs nor the timing.
- R10: `taken_i` and `page_cross_i` count only in the first cycle after a branch strobe. They have no effect for non-branch opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 8 | Opcode to decode |
| valid_i | input | 1 | Opcode strobe |
| taken_i | input | 1 | Branch condition met |
| page_cross_i | input | 1 | Branch target lies in another page |
| group_o | output | 2 | Operation group field |
| op_o | output | 3 | Operation field |
| mode_o | output | 3 | Addressing-mode field |
| illegal_o | output | 1 | Opcode not implemented |
| done_o | output | 1 | Last cycle of the instruction |

## Verification
The end of one instruction (`done_o`) and the acceptance of the next strobe can fall in the same cycle. The bench provokes this by strobing 0x00 in the done cycle of 0xA9. It judges the result by the new field outputs and by a 7-cycle distance to the next pulse. The bench also strobes in the middle of a countdown, and expects the running count and the latched fields to stay untouched. Branch extension is exercised for every branch opcode under all combinations of the taken and page-crossing inputs.

// File: rtl/op_cycle_pkg.sv
package op_cycle_pkg;
  localparam int unsigned OPC_W = 8;
  localparam int unsigned CNT_W = 4;

  typedef struct packed {
    logic [2:0] op;
    logic [2:0] mode;
    logic [1:0] grp;
  } opc_fields_t;

  // base cycle budget, 0 = not implemented
  function automatic logic [CNT_W-1:0] base_cycles(input logic [OPC_W-1:0] opc);
    logic [2:0] a, b;
    logic [1:0] c;
    logic [CNT_W-1:0] n;
    a = opc[7:5]; b = opc[4:2]; c = opc[1:0];
    n = '0;
    unique case (c)
      2'b01: begin
        unique case (b)
          3'd0: n = 6;
          3'd1: n = 3;
          3'd2: n = (a == 3'd4) ? 0 : 2;
          3'd3: n = 4;
          3'd4: n = (a == 3'd4) ? 6 : 5;
          3'd5: n = 4;
          default: n = (a == 3'd4) ? 5 : 4;
        endcase
      end
      2'b10: begin
        if (a == 3'd4) begin
          unique case (b)
            3'd1: n = 3; 3'd2: n = 2; 3'd3: n = 4; 3'd5: n = 4; 3'd6: n = 2;
            default: n = 0;
          endcase
        end else if (a == 3'd5) begin
          unique case (b)
            3'd0: n = 2; 3'd1: n = 3; 3'd2: n = 2; 3'd3: n = 4;
            3'd5: n = 4; 3'd6: n = 2; 3'd7: n = 4;
            default: n = 0;
          endcase
        end else begin
          unique case (b)
            3'd1: n = 5; 3'd2: n = 2; 3'd3: n = 6; 3'd5: n = 6; 3'd7: n = 7;
            default: n = 0;
          endcase
        end
      end
      2'b00: begin
        unique case (b)
          3'd0: unique case (a)
                  3'd0: n = 7;
                  3'd1, 3'd2, 3'd3: n = 6;
                  3'd4: n = 0;
                  default: n = 2;
                endcase
          3'd1: n = (a == 3'd0 || a == 3'd2 || a == 3'd3) ? 0 : 3;
          3'd2: n = (a == 3'd1 || a == 3'd3) ? 4 : (a < 3'd4 ? 3 : 2);
          3'd3: unique case (a)
                  3'd0: n = 0;
                  3'd2: n = 3;
                  3'd3: n = 5;
                  default: n = 4;
                endcase
          3'd4, 3'd6: n = 2;
          3'd5: n = (a == 3'd4 || a == 3'd5) ? 4 : 0;
          default: n = (a == 3'd5) ? 4 : 0;
        endcase
      end
      default: n = 0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/op_fields.sv
module op_fields
  import op_cycle_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output opc_fields_t      fields_o,
  output logic [CNT_W-1:0] base_o,
  output logic             illegal_o,
  output logic             branch_o
);
  always_comb begin
    fields_o  = opcode_i;
    base_o    = base_cycles(opcode_i);
    illegal_o = (opcode_i[1:0] == 2'b11) || (base_o == '0);
    branch_o  = (opcode_i[1:0] == 2'b00) && (opcode_i[4:2] == 3'b100);
  end
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             branch_i,
  input  logic             taken_i,
  input  logic             page_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, ext;
  logic             first_q;

  always_comb begin
    ext = '0;
    if (first_q && branch_i && taken_i) ext = page_i ? CNT_W'(2) : CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      first_q <= (load_val_i != '0);
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - CNT_W'(1) + ext;
      first_q <= 1'b0;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/op_cycle_ctl.sv
module op_cycle_ctl
  import op_cycle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] opcode_i,
  input  logic       valid_i,
  input  logic       taken_i,
  input  logic       page_cross_i,
  output logic [1:0] group_o,
  output logic [2:0] op_o,
  output logic [2:0] mode_o,
  output logic       illegal_o,
  output logic       done_o
);
  opc_fields_t      f_in, f_q;
  logic [CNT_W-1:0] base_in, base_q;
  logic             ill_in, ill_q, br_in, br_q;
  logic [OPC_W-1:0] opc_q;
  logic             have_q, busy, done, accept;

  op_fields u_dec_in (
    .opcode_i(opcode_i), .fields_o(f_in), .base_o(base_in),
    .illegal_o(ill_in), .branch_o(br_in)
  );

  op_fields u_dec_q (
    .opcode_i(opc_q), .fields_o(f_q), .base_o(base_q),
    .illegal_o(ill_q), .branch_o(br_q)
  );

  assign accept = valid_i && (!busy || done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q  <= '0;
      have_q <= 1'b0;
    end else if (accept) begin
      opc_q  <= opcode_i;
      have_q <= 1'b1;
    end
  end

  cyc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept), .load_val_i(ill_in ? '0 : base_in),
    .branch_i(br_q), .taken_i(taken_i), .page_i(page_cross_i),
    .busy_o(busy), .done_o(done)
  );

  assign group_o   = have_q ? f_q.grp  : '0;
  assign op_o      = have_q ? f_q.op   : '0;
  assign mode_o    = have_q ? f_q.mode : '0;
  assign illegal_o = have_q & ill_q;
  assign done_o    = done;

  logic unused;
  assign unused = ^{f_in, base_q, br_in};
endmodule

// File: rtl/op_cycle_ctl_chk.sv
module op_cycle_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] opcode_i,
  input logic       valid_i,
  input logic [1:0] group_o,
  input logic [2:0] op_o,
  input logic [2:0] mode_o,
  input logic       illegal_o,
  input logic       done_o
);
  a_r7_done_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_grp3_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (group_o == 2'b11) |-> illegal_o);

  a_r3_illegal_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !done_o);

  a_r1_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({group_o, op_o, mode_o, illegal_o}));

  a_r8_reload_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_i && opcode_i == 8'hA9) |=> (!done_o ##1 done_o));
endmodule

bind op_cycle_ctl op_cycle_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .valid_i(valid_i),
  .group_o(group_o), .op_o(op_o), .mode_o(mode_o),
  .illegal_o(illegal_o), .done_o(done_o)
);

// File: tb/op_cycle_ctl_bench.sv
module op_cycle_ctl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_WAIT   = 12;

  logic       clk = 0, rst_n = 0;
  logic [7:0] opcode = 0;
  logic       valid = 0, taken = 0, page = 0;
  logic [1:0] group;
  logic [2:0] op, mode;
  logic       illegal, done;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  op_cycle_ctl u_op_cycle_ctl (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .valid_i(valid),
    .taken_i(taken), .page_cross_i(page), .group_o(group), .op_o(op),
    .mode_o(mode), .illegal_o(illegal), .done_o(done)
  );

  function automatic int ref_cycles(input logic [7:0] o);
    int a, b, c;
    a = o[7:5]; b = o[4:2]; c = o[1:0];
    if (c == 3) return 0;
    if (c == 1) begin
      if (o == 8'h89) return 0;
      case (b)
        0: return 6; 1: return 3; 2: return 2; 3: return 4; 5: return 4;
        4: return (a == 4) ? 6 : 5;
        default: return (a == 4) ? 5 : 4;
      endcase
    end
    if (c == 2) begin
      if (a == 4) case (b) 1: return 3; 2: return 2; 3: return 4; 5: return 4; 6: return 2; default: return 0; endcase
      if (a == 5) return (b == 4) ? 0 : ((b == 1) ? 3 : ((b == 0 || b == 2 || b == 6) ? 2 : 4));
      case (b) 1: return 5; 2: return 2; 3: return 6; 5: return 6; 7: return 7; default: return 0; endcase
    end
    if (b == 4 || b == 6) return 2;
    case (o)
      8'h00: return 7; 8'h20, 8'h40, 8'h60: return 6;
      8'hA0, 8'hC0, 8'hE0: return 2;
      8'h24, 8'h84, 8'hA4, 8'hC4, 8'hE4: return 3;
      8'h08, 8'h48: return 3; 8'h28, 8'h68: return 4;
      8'h88, 8'hA8, 8'hC8, 8'hE8: return 2;
      8'h2C, 8'h8C, 8'hAC, 8'hCC, 8'hEC: return 4;
      8'h4C: return 3; 8'h6C: return 5;
      8'h94, 8'hB4, 8'hBC: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] o);
    opcode = o; valid = 1;
    @(negedge clk);
    valid = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int k = 1; k <= MAX_WAIT; k++) begin
      if (done) begin n = k; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, e;
    repeat (3) @(negedge clk);
    chk({group, op, mode, illegal, done} == 0, "R1 reset", {group, op, mode, illegal, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // every opcode, no branch extension
    for (int i = 0; i < 256; i++) begin
      logic [7:0] o;
      o = 8'(i);
      e = ref_cycles(o);
      strobe(o);
      chk({group, op, mode} == {o[1:0], o[7:5], o[4:2]}, "R1 fields", {group, op, mode}, {o[1:0], o[7:5], o[4:2]});
      if (o[1:0] == 2'b11) chk(illegal == 1, "R2 group 3 illegal", illegal, 1);
      else chk(illegal == (e == 0), "R3 illegal flag", illegal, e == 0);
      wait_done(n);
      chk(n == e, (e == 0) ? "R3 no countdown" : "R4 base cycles", n, e);
      if (n != 0) begin
        @(negedge clk);
        chk(done == 0, "R7 single pulse", done, 0);
      end
    end

    // branches with all outcome combinations
    for (int a = 0; a < 8; a++) begin
      for (int t = 0; t < 4; t++) begin
        logic [7:0] o;
        o = {3'(a), 5'b10000};
        opcode = o; valid = 1;
        @(negedge clk);
        valid = 0; taken = t[0]; page = t[1];
        wait_done(n);
        taken = 0; page = 0;
        e = 2 + t[0] + (t[0] & t[1]);
        chk(n == e, t[1] ? "R6 page cross" : "R5 taken", n, e);
        @(negedge clk);
      end
    end

    // R10: inputs ignored for non-branch opcode
    opcode = 8'hAD; valid = 1;
    @(negedge clk);
    valid = 0; taken = 1; page = 1;
    wait_done(n);
    chk(n == 4, "R10 non-branch ignores taken", n, 4);
    taken = 0; page = 0;
    @(negedge clk);

    // R10: taken raised after first countdown cycle of a branch
    strobe(8'hD0);
    @(negedge clk);
    taken = 1; page = 1;
    chk(done == 1, "R10 late taken ignored", done, 1);
    @(negedge clk);
    taken = 0; page = 0;
    chk(done == 0, "R10 late taken ignored", done, 0);

    // R8: reload in done cycle
    strobe(8'hA9);
    wait_done(n);
    chk(n == 2, "R8 first instr", n, 2);
    strobe(8'h00);
    chk({group, op, mode} == 8'h00, "R8 reload fields", {group, op, mode}, 0);
    wait_done(n);
    chk(n == 7, "R8 reload cycles", n, 7);
    strobe(8'hA9); // again in done cycle, exercises checker
    wait_done(n);
    chk(n == 2, "R8 back-to-back", n, 2);
    @(negedge clk);

    // R9: strobe mid-countdown ignored
    strobe(8'h1E);
    @(negedge clk);
    strobe(8'hA9);
    chk({group, op, mode} == {2'b10, 3'b000, 3'b111}, "R9 fields kept", {group, op, mode}, {2'b10, 3'b000, 3'b111});
    wait_done(n);
    chk(n + 2 == 7, "R9 timing kept", n + 2, 7);
    @(negedge clk);

    // R4 spot values
    strobe(8'h9D); wait_done(n); chk(n == 5, "R4 0x9D", n, 5); @(negedge clk);
    strobe(8'h20); wait_done(n); chk(n == 6, "R4 0x20", n, 6); @(negedge clk);
    strobe(8'h89); wait_done(n); chk(n == 0 && illegal, "R3 0x89", n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule